// File: doc/BRIEF.md
# Adaptive security primitive controller

This block sequences a reconfigurable cipher accelerator through its life cycle: it learns what the platform can currently afford, waits for the host to choose its algorithm settings, asks an external reconfiguration engine to load the matching image, lets the datapath run, and parks or unloads it on command. Host access is a small register window. A writes port loads settings and issues commands. A separate read address returns one register through a combinational path. Battery level, link quality and the current threat class come from a system monitor.

The controller picks the image number from the host's settings, the performance policy, the two sensor readings and the threat class. In best-effort operation a weak battery or a poor link moves the primitive to a low-power image. In guaranteed operation the host's choice is kept. Any change of the threat class overrides the normal flow and forces a reload from whatever state the controller is in. If that change arrives while a load is still outstanding, the controller waits for that load to finish and then starts a new one. While the primitive runs, a programmable interval timer arms a sensor re-check, and the re-check is only evaluated when the datapath reports the end of a block.

Top module: `secprim_ctrl`

## Requirements
- R1: After reset the status register (host address 3) reads 0: state code 0 = INIT in bits 1:0 and the I/O stall flag in bit 2 clear. `cfg_req`, `dp_run` and `dp_rst` are low.
- R2: The allowed-options register (address 2) has these bits: bit0 no reliability, bit1 parity detection, bit2 triple redundancy, bit3 128-bit key, bit4 192-bit key, bit5 256-bit key, bit6 high-throughput image, bit7 zero. Bits 0, 1 and 3 are always set. Bits 2, 4 and 5 need battery >= BATT_THR. Bit 6 needs both battery >= BATT_THR and link >= CHAN_THR. The register is refreshed on every cycle in INIT and at each run-time re-check.
- R3: In INIT no load is requested until the host writes the algorithm register (address 0: bit0 mode, bits 2:1 key code). After that write one load is requested. The image number is {low_power, mode, reliability[1:0]}, with reliability taken from the architecture register (address 1: bits 1:0 reliability code 0 none, 1 parity, 2 triple; bit2 policy, 1 = guaranteed).
- R4: In CONFIG `dp_rst` is high and `cfg_req` pulses for one cycle with `cfg_sel` held until the next pulse. The state (code 1) becomes RUN (code 2) only after `cfg_done`, and then `dp_run` is high.
- R5: A run-time re-check happens only when two conditions hold together: at least PERIOD cycles (address 4) have passed in RUN, and `blk_done` is high. When the period has elapsed but no block has ended, or a block ends before the period, nothing is reconfigured.
- R6: Under best-effort policy, a re-check that finds battery or link below threshold reloads with low_power = 1. A later re-check with both sensors good reloads the normal image.
- R7: Under guaranteed policy a re-check with low sensors keeps the current image and the state stays RUN.
- R8: Threat code 1 (hijack) loads image 4'b0001: no low power, mode 0, parity. Threat code 2 (denial of service) loads {0, mode, 2'b10}, which is triple redundancy.
- R9: Threat code 3 (extraction) sets status bit 2 and holds `dp_run` low, including while in RUN.
- R10: When the threat code returns to 0, the controller reloads the image chosen by the normal policy rather than keeping the protected one.
- R11: A threat change while a load is outstanding causes a second request right after `cfg_done`, carrying the new selection, and the state does not pass through RUN in between.
- R12: Writing address 3 issues commands: bit1 stop (RUN to STOP, code 3), bit0 go (STOP to RUN without a new load), bit2 unload (STOP to INIT).
- R13: A threat change forces the state to CONFIG from INIT, RUN or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_rd_addr | input | 3 | Host read address |
| host_rdata | output | 8 | Host read data (combinational) |
| batt_level | input | SENS_W | Battery level from the monitor |
| chan_qual | input | SENS_W | Link quality from the monitor |
| threat_kind | input | 2 | Current threat class: 0 none, 1 hijack, 2 denial of service, 3 extraction |
| blk_done | input | 1 | Datapath finished a block |
| cfg_req | output | 1 | One-cycle request to load an image |
| cfg_sel | output | 4 | Image number {low_power, mode, reliability} |
| cfg_done | input | 1 | Reconfiguration engine finished |
| dp_rst | output | 1 | Datapath held in reset |
| dp_run | output | 1 | Datapath enabled to process data |
| io_stall | output | 1 | Datapath I/O stalled |

## Verification
The hardest case to reach is a threat change that lands while a load is still outstanding. The stimulus gets there with a bench-side engine model that answers every request after a fixed three-cycle delay. The threat code is changed on the cycle right after a request is seen. The bench then watches the status on every cycle until the second request appears, to confirm that RUN was never visited in between. The re-check gate is also hard to hit, because it needs an elapsed timer and a block boundary together. The bench reaches it by letting the period expire with no block, then pulsing `blk_done` alone.

// File: rtl/secprim_pkg.sv
package secprim_pkg;
  typedef enum logic [1:0] {ST_INIT = 2'd0, ST_CONFIG = 2'd1, ST_RUN = 2'd2, ST_STOP = 2'd3} ctrl_state_e;

  localparam logic [1:0] REL_NONE   = 2'd0;
  localparam logic [1:0] REL_PARITY = 2'd1;
  localparam logic [1:0] REL_TMR    = 2'd2;

  localparam logic [1:0] THR_NONE   = 2'd0;
  localparam logic [1:0] THR_HIJACK = 2'd1;
  localparam logic [1:0] THR_DOS    = 2'd2;
  localparam logic [1:0] THR_LEAK   = 2'd3;

  localparam logic [2:0] RA_ALG    = 3'd0;
  localparam logic [2:0] RA_ARCH   = 3'd1;
  localparam logic [2:0] RA_ALLOW  = 3'd2;
  localparam logic [2:0] RA_STATUS = 3'd3;
  localparam logic [2:0] RA_PERIOD = 3'd4;

  // image number = {low_power, mode, reliability}
  function automatic logic [3:0] pick_image(input logic mode, input logic [1:0] rel,
                                            input logic guaranteed, input logic batt_ok,
                                            input logic chan_ok, input logic [1:0] threat);
    logic lp;
    lp = !guaranteed && !(batt_ok && chan_ok);
    case (threat)
      THR_HIJACK: pick_image = {1'b0, 1'b0, REL_PARITY};
      THR_DOS:    pick_image = {1'b0, mode, REL_TMR};
      default:    pick_image = {lp, mode, rel};
    endcase
  endfunction

  function automatic logic [7:0] options_mask(input logic batt_ok, input logic chan_ok);
    options_mask = {1'b0, batt_ok && chan_ok, batt_ok, batt_ok, 1'b1, batt_ok, 1'b1, 1'b1};
  endfunction
endpackage

// File: rtl/secprim_sensor_eval.sv
module secprim_sensor_eval #(
  parameter int SENS_W   = 8,
  parameter int BATT_THR = 100,
  parameter int CHAN_THR = 100
) (
  input  logic [SENS_W-1:0] batt_level,
  input  logic [SENS_W-1:0] chan_qual,
  output logic              batt_ok,
  output logic              chan_ok,
  output logic [7:0]        allowed
);
  import secprim_pkg::*;
  localparam logic [SENS_W-1:0] BATT_LIM = SENS_W'(BATT_THR);
  localparam logic [SENS_W-1:0] CHAN_LIM = SENS_W'(CHAN_THR);

  always_comb begin
    batt_ok = batt_level >= BATT_LIM;
    chan_ok = chan_qual >= CHAN_LIM;
    allowed = options_mask(batt_ok, chan_ok);
  end
endmodule

// File: rtl/secprim_poll_timer.sv
module secprim_poll_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  output logic             due
);
  logic [CNT_W-1:0] cnt_q;

  assign due = cnt_q >= period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || !run)  cnt_q <= '0;
    else if (!due)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/secprim_cfg_pick.sv
module secprim_cfg_pick (
  input  logic       mode,
  input  logic [1:0] rel,
  input  logic       guaranteed,
  input  logic       batt_ok,
  input  logic       chan_ok,
  input  logic [1:0] threat,
  output logic [3:0] image
);
  import secprim_pkg::*;
  assign image = pick_image(mode, rel, guaranteed, batt_ok, chan_ok, threat);
endmodule

// File: rtl/secprim_ctrl.sv
module secprim_ctrl #(
  parameter int SENS_W      = 8,
  parameter int BATT_THR    = 100,
  parameter int CHAN_THR    = 100,
  parameter int POLL_RESET  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  input  logic [2:0]        host_rd_addr,
  output logic [7:0]        host_rdata,
  input  logic [SENS_W-1:0] batt_level,
  input  logic [SENS_W-1:0] chan_qual,
  input  logic [1:0]        threat_kind,
  input  logic              blk_done,
  output logic              cfg_req,
  output logic [3:0]        cfg_sel,
  input  logic              cfg_done,
  output logic              dp_rst,
  output logic              dp_run,
  output logic              io_stall
);
  import secprim_pkg::*;
  localparam int PER_W = 8;

  ctrl_state_e      state_q;
  logic             busy_q, pend_q, cfg_req_q, alg_pend_q;
  logic [3:0]       cfg_sel_q;
  logic [1:0]       threat_q;
  logic [7:0]       allowed_q;
  logic             alg_mode_q, arch_gtd_q;
  logic [1:0]       alg_key_q, arch_rel_q;
  logic [PER_W-1:0] period_q;

  // named internal events
  logic       sec_event, poll_due, poll_fire, batt_ok, chan_ok;
  logic       wr_alg, wr_arch, wr_cmd, wr_per, cmd_go, cmd_stop, cmd_unload;
  logic [7:0] live_mask;
  logic [3:0] pick_img;

  assign wr_alg     = host_wr && host_addr == RA_ALG;
  assign wr_arch    = host_wr && host_addr == RA_ARCH;
  assign wr_cmd     = host_wr && host_addr == RA_STATUS;
  assign wr_per     = host_wr && host_addr == RA_PERIOD;
  assign cmd_go     = wr_cmd && host_wdata[0];
  assign cmd_stop   = wr_cmd && host_wdata[1];
  assign cmd_unload = wr_cmd && host_wdata[2];
  assign sec_event  = threat_kind != threat_q;
  assign poll_fire  = state_q == ST_RUN && poll_due && blk_done;

  secprim_sensor_eval #(.SENS_W(SENS_W), .BATT_THR(BATT_THR), .CHAN_THR(CHAN_THR)) u_sens (
    .batt_level(batt_level), .chan_qual(chan_qual),
    .batt_ok(batt_ok), .chan_ok(chan_ok), .allowed(live_mask));

  secprim_poll_timer #(.CNT_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_RUN), .clr(poll_fire),
    .period(period_q), .due(poll_due));

  secprim_cfg_pick u_pick (
    .mode(alg_mode_q), .rel(arch_rel_q), .guaranteed(arch_gtd_q),
    .batt_ok(batt_ok), .chan_ok(chan_ok), .threat(threat_q), .image(pick_img));

  // host-visible settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alg_mode_q <= 1'b0; alg_key_q <= 2'd0;
      arch_rel_q <= REL_NONE; arch_gtd_q <= 1'b0;
      period_q   <= PER_W'(POLL_RESET);
      alg_pend_q <= 1'b0;
    end else begin
      if (wr_alg) begin
        alg_mode_q <= host_wdata[0];
        alg_key_q  <= host_wdata[2:1];
      end
      if (wr_arch) begin
        arch_rel_q <= host_wdata[1:0];
        arch_gtd_q <= host_wdata[2];
      end
      if (wr_per) period_q <= host_wdata[PER_W-1:0];
      if (wr_alg)                                   alg_pend_q <= 1'b1;
      else if (state_q == ST_CONFIG && !busy_q)     alg_pend_q <= 1'b0;
    end
  end

  // life-cycle sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INIT;
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      cfg_req_q <= 1'b0;
      cfg_sel_q <= 4'd0;
      threat_q  <= THR_NONE;
      allowed_q <= 8'd0;
    end else begin
      threat_q  <= threat_kind;
      cfg_req_q <= 1'b0;
      unique case (state_q)
        ST_INIT: begin
          allowed_q <= live_mask;
          if (sec_event || alg_pend_q) state_q <= ST_CONFIG;
        end
        ST_CONFIG: begin
          if (!busy_q) begin
            cfg_req_q <= 1'b1;
            cfg_sel_q <= pick_img;
            busy_q    <= 1'b1;
            if (sec_event) pend_q <= 1'b1;
          end else if (cfg_done) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            if (!(pend_q || sec_event)) state_q <= ST_RUN;
          end else if (sec_event) begin
            pend_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (sec_event)      state_q <= ST_CONFIG;
          else if (cmd_stop)  state_q <= ST_STOP;
          else if (poll_fire) begin
            allowed_q <= live_mask;
            if (pick_img != cfg_sel_q) state_q <= ST_CONFIG;
          end
        end
        ST_STOP: begin
          if (sec_event)       state_q <= ST_CONFIG;
          else if (cmd_go)     state_q <= ST_RUN;
          else if (cmd_unload) state_q <= ST_INIT;
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end

  assign cfg_req  = cfg_req_q;
  assign cfg_sel  = cfg_sel_q;
  assign io_stall = threat_q == THR_LEAK;
  assign dp_rst   = state_q == ST_CONFIG;
  assign dp_run   = state_q == ST_RUN && !io_stall;

  always_comb begin
    case (host_rd_addr)
      RA_ALG:    host_rdata = {5'd0, alg_key_q, alg_mode_q};
      RA_ARCH:   host_rdata = {5'd0, arch_gtd_q, arch_rel_q};
      RA_ALLOW:  host_rdata = allowed_q;
      RA_STATUS: host_rdata = {5'd0, io_stall, state_q};
      RA_PERIOD: host_rdata = period_q;
      default:   host_rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/secprim_ctrl_checker.sv
module secprim_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       sec_event,
  input logic       busy,
  input logic       cfg_req,
  input logic [3:0] cfg_sel,
  input logic       cfg_done,
  input logic       blk_done,
  input logic       io_stall,
  input logic       dp_run
);
  localparam logic [1:0] S_CONFIG = 2'd1;
  localparam logic [1:0] S_RUN    = 2'd2;

  p_req_in_config_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (state == S_CONFIG && busy));

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_sel) |-> cfg_req);

  p_run_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && $past(state) == S_CONFIG) |-> $past(cfg_done));

  p_poll_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_RUN && state == S_CONFIG && !$past(sec_event)) |-> $past(blk_done));

  p_stall_blocks_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_stall |-> !dp_run);

  p_pending_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONFIG && busy && cfg_done && sec_event) |=> (state == S_CONFIG));

  p_override_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_event && state != S_CONFIG) |=> (state == S_CONFIG));
endmodule

bind secprim_ctrl secprim_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .sec_event(sec_event), .busy(busy_q),
  .cfg_req(cfg_req), .cfg_sel(cfg_sel), .cfg_done(cfg_done), .blk_done(blk_done),
  .io_stall(io_stall), .dp_run(dp_run));

// File: tb/secprim_ctrl_bench.sv
`timescale 1ns/1ps
module secprim_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [2:0] host_addr = 3'd0, host_rd_addr = 3'd3;
  logic [7:0] host_wdata = 8'd0, host_rdata;
  logic [7:0] batt_level = 8'd200, chan_qual = 8'd200;
  logic [1:0] threat_kind = 2'd0;
  logic       blk_done = 1'b0, cfg_done = 1'b0;
  logic       cfg_req, dp_rst, dp_run, io_stall;
  logic [3:0] cfg_sel;

  int checks = 0, errors = 0, reqs = 0, lat = 0;
  logic [3:0] last_sel = 4'd0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  secprim_ctrl u_secprim_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd_addr(host_rd_addr), .host_rdata(host_rdata),
    .batt_level(batt_level), .chan_qual(chan_qual), .threat_kind(threat_kind),
    .blk_done(blk_done), .cfg_req(cfg_req), .cfg_sel(cfg_sel), .cfg_done(cfg_done),
    .dp_rst(dp_rst), .dp_run(dp_run), .io_stall(io_stall));

  // reconfiguration engine model: done three cycles after each request
  initial forever begin
    @(negedge clk);
    cfg_done = 1'b0;
    if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) cfg_done = 1'b1;
    end
    if (cfg_req) begin
      reqs = reqs + 1;
      last_sel = cfg_sel;
      lat = 3;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_rd_addr = a; #1; d = host_rdata; host_rd_addr = 3'd3;
  endtask

  function automatic int st();
    return int'(host_rdata[1:0]);
  endfunction

  task automatic wait_state(input int s);
    for (int i = 0; i < 200; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      if (st() == s) return;
    end
  endtask

  task automatic pulse_blk();
    @(negedge clk); blk_done = 1'b1;
    @(negedge clk); blk_done = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 status", host_rdata, 0);
    chk("R1 cfg_req", cfg_req, 0);
    chk("R1 dp_run", dp_run, 0);
    chk("R1 dp_rst", dp_rst, 0);
  endtask

  task automatic t_allowed();
    logic [7:0] d;
    batt_level = 8'd200; chan_qual = 8'd200; cyc(2); rd(3'd2, d);
    chk("R2 all good", d, 8'h7F);
    batt_level = 8'd50; cyc(2); rd(3'd2, d);
    chk("R2 low battery", d, 8'h0B);
    batt_level = 8'd200; chan_qual = 8'd50; cyc(2); rd(3'd2, d);
    chk("R2 poor link", d, 8'h3F);
    chan_qual = 8'd200; cyc(2);
  endtask

  task automatic t_first_load();
    cyc(10);
    chk("R3 no load before alg write", reqs, 0);
    wr(3'd1, 8'h01);
    wr(3'd4, 8'd20);
    wr(3'd0, 8'h01);
    cyc(2); #1;
    chk("R4 dp_rst in config", dp_rst, 1);
    wait_state(2);
    chk("R3 one load", reqs, 1);
    chk("R3 image", last_sel, 5);
    chk("R4 run state", st(), 2);
    chk("R4 dp_run", dp_run, 1);
  endtask

  task automatic t_poll_downgrade();
    int n;
    n = reqs;
    batt_level = 8'd50;
    pulse_blk(); cyc(4);
    chk("R5 early block ignored", reqs, n);
    cyc(25);
    chk("R5 no block, no recheck", reqs, n);
    pulse_blk(); cyc(2); wait_state(2);
    chk("R6 downgrade load", reqs, n + 1);
    chk("R6 low power image", last_sel, 13);
    batt_level = 8'd200;
    cyc(25); pulse_blk(); cyc(2); wait_state(2);
    chk("R6 recovery image", last_sel, 5);
  endtask

  task automatic t_guaranteed();
    int n;
    wr(3'd1, 8'h05);
    n = reqs;
    batt_level = 8'd50;
    cyc(25); pulse_blk(); cyc(6); #1;
    chk("R7 no reload", reqs, n);
    chk("R7 still running", st(), 2);
    batt_level = 8'd200;
    wr(3'd1, 8'h01);
  endtask

  task automatic threat(input logic [1:0] k, input int exp_sel, input string tag);
    int n;
    n = reqs;
    @(negedge clk); threat_kind = k;
    cyc(2); wait_state(2);
    chk({tag, " load issued"}, reqs, n + 1);
    chk({tag, " image"}, last_sel, exp_sel);
  endtask

  task automatic t_threats();
    logic [7:0] d;
    threat(2'd1, 1, "R8 hijack");
    threat(2'd0, 5, "R10 cleared after hijack");
    threat(2'd2, 6, "R8 denial of service");
    threat(2'd0, 5, "R10 cleared after dos");
    threat(2'd3, 5, "R9 extraction");
    rd(3'd3, d);
    chk("R9 stall flag", d[2], 1);
    chk("R9 dp_run held low", dp_run, 0);
    threat(2'd0, 5, "R10 cleared after extraction");
    chk("R10 dp_run restored", dp_run, 1);
  endtask

  task automatic t_override_busy();
    int n, ran;
    n = reqs; ran = 0;
    @(negedge clk); threat_kind = 2'd2;
    for (int i = 0; i < 50 && reqs == n; i++) @(negedge clk);
    threat_kind = 2'd0;
    for (int i = 0; i < 50 && reqs < n + 2; i++) begin
      @(negedge clk); #1;
      if (st() == 2) ran = 1;
    end
    chk("R11 second load", reqs, n + 2);
    chk("R11 no run between loads", ran, 0);
    chk("R11 new image", last_sel, 5);
    wait_state(2);
  endtask

  task automatic t_stop_go();
    int n;
    n = reqs;
    wr(3'd3, 8'h02); #1;
    chk("R12 stop", st(), 3);
    chk("R12 dp_run in stop", dp_run, 0);
    wr(3'd3, 8'h01); #1;
    chk("R12 go", st(), 2);
    chk("R12 no reload on go", reqs, n);
    wr(3'd3, 8'h02);
    @(negedge clk); threat_kind = 2'd1;
    @(negedge clk); #1;
    chk("R13 override from stop", st(), 1);
    wait_state(2);
    chk("R13 hijack image", last_sel, 1);
    threat(2'd0, 5, "R13 cleared");
    wr(3'd3, 8'h02);
    wr(3'd3, 8'h04); #1;
    chk("R12 unload", st(), 0);
    n = reqs;
    cyc(8);
    chk("R12 idle after unload", reqs, n);
    @(negedge clk); threat_kind = 2'd2;
    @(negedge clk); #1;
    chk("R13 override from init", st(), 1);
    @(negedge clk); threat_kind = 2'd0;
    wait_state(2);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_allowed();
    t_first_load();
    t_poll_downgrade();
    t_guaranteed();
    t_threats();
    t_override_busy();
    t_stop_go();
    cyc(4);
    finish_run();
  end
endmodule